// File: doc/BRIEF.md
# DRAM DLL-Off Transition Sequencer

This block sits in a memory controller and walks an idle DDR3-class device from DLL-enabled operation into DLL-disabled operation at a new clock rate. After a start request it writes the DLL-disable bit through a mode-register write. It then parks the device in self-refresh and asks the clock generator for the new frequency. Once the new clock has settled, it brings the device out of self-refresh and rewrites the latency-related mode registers. An optional long ZQ calibration follows, and the block then signals that the device can accept ordinary traffic.

Every gap between steps comes from a run-time cycle count on an input port, and a count of zero is treated as one. The block drives CKE and ODT throughout the transition. ODT is forced low whenever either termination feature is enabled, so the device never sees it asserted while its DLL state and latencies are changing.

Top module: `dll_off_sequencer`

## Requirements
- R1: While reset is held and in the cycle after its release, cmd_o is NOP, cke_o is 1, freq_req_o, done_o and err_o are 0, and odt_o is 0.
- R2: Command codes on cmd_o are NOP=0, MRS=1, SRE=2, SRX=3, ZQCL=4. Register selects on mr_sel_o are MR0=0, MR1=1, MR2=2. A start_i sampled high while the block is idle or done and mem_idle_i is high produces, in the next cycle, an MRS with mr_sel_o=1 and mr_data_o equal to mr1_cfg_i with bit 0 forced to 1.
- R3: SRE appears exactly t_mod_i cycles after the MR1 write. cke_o falls in the SRE cycle.
- R4: freq_req_o rises exactly t_cksre_i cycles after SRE and stays high up to the cycle before SRX.
- R5: Let j be the first cycle of the final unbroken run of clk_stable_i samples taken while freq_req_o is high. SRX appears at the later of j plus t_cksrx_i and the SRE cycle plus t_ckesr_i. Any low sample restarts the run.
- R6: cke_o stays low from SRE up to the cycle before SRX. It is high in the SRX cycle and in every cycle after it until the next SRE.
- R7: If rtt_nom_en_i or rtt_wr_en_i is set, odt_o is 0 from the MR1 write cycle through the cycle before done_o rises. In all other cycles odt_o is odt_req_i delayed by one cycle.
- R8: An MRS to MR2 carrying mr2_cfg_i appears t_xs_i cycles after SRX. An MRS to MR0 carrying mr0_cfg_i follows t_mod_i cycles later.
- R9: If zq_en_i is set, ZQCL appears t_mod_i cycles after the MR0 write and done_o rises one cycle after ZQCL. Otherwise done_o rises t_mod_i cycles after the MR0 write. done_o stays high until the next start is accepted.
- R10: cmd_o is NOP in every cycle that carries none of the commands listed above. Each command lasts exactly one cycle.
- R11: A start_i sampled while a transition is running, or while mem_idle_i is low, makes err_o high for one cycle and changes nothing else.
- R12: A timing input of 0 behaves exactly as a value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin the transition |
| mem_idle_i | input | 1 | Device idle: banks precharged, prior timings met, termination off |
| clk_stable_i | input | 1 | New clock is running and stable |
| odt_req_i | input | 1 | ODT level wanted by the controller |
| rtt_nom_en_i | input | 1 | Nominal termination enabled |
| rtt_wr_en_i | input | 1 | Dynamic write termination enabled |
| zq_en_i | input | 1 | Issue a long ZQ calibration at the end |
| t_mod_i | input | TW | Mode-register update gap, cycles |
| t_cksre_i | input | TW | Clock hold after self-refresh entry, cycles |
| t_cksrx_i | input | TW | Stable-clock time before self-refresh exit, cycles |
| t_xs_i | input | TW | Exit-to-command gap, cycles |
| t_ckesr_i | input | TW | Minimum CKE-low time in self-refresh, cycles |
| mr0_cfg_i | input | AW | MR0 value for DLL-off operation |
| mr1_cfg_i | input | AW | MR1 value; bit 0 is forced high |
| mr2_cfg_i | input | AW | MR2 value for DLL-off operation |
| cmd_o | output | 3 | Command code |
| mr_sel_o | output | 2 | Mode-register select on MRS cycles |
| mr_data_o | output | AW | Mode-register payload on MRS cycles |
| cke_o | output | 1 | Clock enable to the device |
| odt_o | output | 1 | On-die termination control |
| freq_req_o | output | 1 | Request to the clock generator to switch frequency |
| done_o | output | 1 | Device ready for any valid command |
| err_o | output | 1 | Start request rejected |

## Verification
The timing inputs are swept across small values, with t_ckesr_i taken both below and above the self-refresh dwell. This separates an SRX placed by the stable-clock run from one placed by the CKE-low minimum. The delay before the clock settles is varied, and a one-cycle stable pulse followed by a drop shows whether the run restarts or keeps counting. All four termination combinations are run with odt_req_i held high, so that a masked ODT can be told apart from a passed-through one. Runs with and without ZQ calibration check where done_o lands. Directed runs also cover zero timing values, a start request in the middle of a transition, and a start request while the device is not idle.

// File: rtl/dll_off_pkg.sv
package dll_off_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_MRS  = 3'd1,
    CMD_SRE  = 3'd2,
    CMD_SRX  = 3'd3,
    CMD_ZQCL = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MR1,
    ST_SRE,
    ST_FREQ,
    ST_XS,
    ST_MRW,
    ST_ZQ,
    ST_DONE
  } seq_st_e;

  localparam logic [1:0] SEL_MR0 = 2'd0;
  localparam logic [1:0] SEL_MR1 = 2'd1;
  localparam logic [1:0] SEL_MR2 = 2'd2;

endpackage

// File: rtl/dll_off_gap_timer.sv
module dll_off_gap_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          expired_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] len_eff;

  // a programmed zero is stretched to one cycle
  assign len_eff = (len_i == '0) ? ONE : len_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_eff - ONE;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/dll_off_stable_mon.sv
module dll_off_stable_mon #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          stable_i,
  input  logic [TW-1:0] need_i,
  output logic          hit_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] run_q;
  logic [TW-1:0] need_eff;

  assign need_eff = (need_i == '0) ? ONE : need_i;

  // run_q counts earlier consecutive high samples in the window
  always_ff @(posedge clk) begin
    if (rst || !en_i || !stable_i) begin
      run_q <= '0;
    end else if (run_q != '1) begin
      run_q <= run_q + ONE;
    end
  end

  assign hit_o = en_i && stable_i && (run_q >= need_eff - ONE);

endmodule

// File: rtl/dll_off_sequencer.sv
module dll_off_sequencer
  import dll_off_pkg::*;
#(
  parameter int TW = 8,
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          mem_idle_i,
  input  logic          clk_stable_i,
  input  logic          odt_req_i,
  input  logic          rtt_nom_en_i,
  input  logic          rtt_wr_en_i,
  input  logic          zq_en_i,
  input  logic [TW-1:0] t_mod_i,
  input  logic [TW-1:0] t_cksre_i,
  input  logic [TW-1:0] t_cksrx_i,
  input  logic [TW-1:0] t_xs_i,
  input  logic [TW-1:0] t_ckesr_i,
  input  logic [AW-1:0] mr0_cfg_i,
  input  logic [AW-1:0] mr1_cfg_i,
  input  logic [AW-1:0] mr2_cfg_i,
  output logic [2:0]    cmd_o,
  output logic [1:0]    mr_sel_o,
  output logic [AW-1:0] mr_data_o,
  output logic          cke_o,
  output logic          odt_o,
  output logic          freq_req_o,
  output logic          done_o,
  output logic          err_o
);
  localparam logic [AW-1:0] DLL_DIS_BIT = AW'(1);

  seq_st_e       st_q, st_n;
  logic          idx_q, idx_n;
  logic          term_q, term_n;
  cmd_e          cmd_n;
  logic [1:0]    sel_n;
  logic [AW-1:0] dat_n;
  logic          gap_ld;
  logic [TW-1:0] gap_len;
  logic          gap_exp;
  logic          ckesr_ld;
  logic          ckesr_exp;
  logic          stab_hit;
  logic          accept;
  logic          busy_n;

  cmd_e          cmd_q;
  logic [1:0]    sel_q;
  logic [AW-1:0] dat_q;
  logic          cke_q, odt_q, freq_q, done_q, err_q;

  dll_off_gap_timer #(.TW(TW)) u_gap (
    .clk       (clk),
    .rst       (rst),
    .load_i    (gap_ld),
    .len_i     (gap_len),
    .expired_o (gap_exp)
  );

  dll_off_gap_timer #(.TW(TW)) u_ckesr (
    .clk       (clk),
    .rst       (rst),
    .load_i    (ckesr_ld),
    .len_i     (t_ckesr_i),
    .expired_o (ckesr_exp)
  );

  dll_off_stable_mon #(.TW(TW)) u_stab (
    .clk      (clk),
    .rst      (rst),
    .en_i     (st_q == ST_FREQ),
    .stable_i (clk_stable_i),
    .need_i   (t_cksrx_i),
    .hit_o    (stab_hit)
  );

  always_comb begin
    st_n     = st_q;
    idx_n    = idx_q;
    cmd_n    = CMD_NOP;
    sel_n    = SEL_MR0;
    dat_n    = '0;
    gap_ld   = 1'b0;
    gap_len  = t_mod_i;
    ckesr_ld = 1'b0;
    accept   = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i && mem_idle_i) begin
          accept = 1'b1;
          st_n   = ST_MR1;
          cmd_n  = CMD_MRS;
          sel_n  = SEL_MR1;
          dat_n  = mr1_cfg_i | DLL_DIS_BIT;
          gap_ld = 1'b1;
        end
      end
      ST_MR1: begin
        if (gap_exp) begin
          st_n     = ST_SRE;
          cmd_n    = CMD_SRE;
          gap_ld   = 1'b1;
          gap_len  = t_cksre_i;
          ckesr_ld = 1'b1;
        end
      end
      ST_SRE: begin
        if (gap_exp) st_n = ST_FREQ;
      end
      ST_FREQ: begin
        if (stab_hit && ckesr_exp) begin
          st_n    = ST_XS;
          cmd_n   = CMD_SRX;
          gap_ld  = 1'b1;
          gap_len = t_xs_i;
        end
      end
      ST_XS: begin
        if (gap_exp) begin
          st_n   = ST_MRW;
          idx_n  = 1'b0;
          cmd_n  = CMD_MRS;
          sel_n  = SEL_MR2;
          dat_n  = mr2_cfg_i;
          gap_ld = 1'b1;
        end
      end
      ST_MRW: begin
        if (gap_exp) begin
          if (!idx_q) begin
            idx_n  = 1'b1;
            cmd_n  = CMD_MRS;
            sel_n  = SEL_MR0;
            dat_n  = mr0_cfg_i;
            gap_ld = 1'b1;
          end else if (zq_en_i) begin
            st_n  = ST_ZQ;
            cmd_n = CMD_ZQCL;
          end else begin
            st_n = ST_DONE;
          end
        end
      end
      ST_ZQ: st_n = ST_DONE;
      default: st_n = ST_IDLE;
    endcase
  end

  // termination setting captured at start and again at self-refresh entry
  assign term_n = (accept || ckesr_ld) ? (rtt_nom_en_i || rtt_wr_en_i) : term_q;
  assign busy_n = (st_n != ST_IDLE) && (st_n != ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      idx_q  <= 1'b0;
      term_q <= 1'b0;
      cmd_q  <= CMD_NOP;
      sel_q  <= SEL_MR0;
      dat_q  <= '0;
      cke_q  <= 1'b1;
      odt_q  <= 1'b0;
      freq_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      term_q <= term_n;
      cmd_q  <= cmd_n;
      sel_q  <= sel_n;
      dat_q  <= dat_n;
      cke_q  <= !((st_n == ST_SRE) || (st_n == ST_FREQ));
      odt_q  <= odt_req_i && !(busy_n && term_n);
      freq_q <= (st_n == ST_FREQ);
      done_q <= (st_n == ST_DONE);
      err_q  <= start_i && !accept;
    end
  end

  assign cmd_o      = cmd_q;
  assign mr_sel_o   = sel_q;
  assign mr_data_o  = dat_q;
  assign cke_o      = cke_q;
  assign odt_o      = odt_q;
  assign freq_req_o = freq_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

endmodule

// File: rtl/dll_off_sequencer_chk.sv
module dll_off_sequencer_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          clk_stable_i,
  input logic [2:0]    cmd_o,
  input logic [1:0]    mr_sel_o,
  input logic [AW-1:0] mr_data_o,
  input logic          cke_o,
  input logic          freq_req_o,
  input logic          done_o,
  input logic          err_o
);

  // R3
  sre_cke_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cke_o) |-> cmd_o == 3'd2);

  // R6
  srx_cke_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_o) |-> cmd_o == 3'd3);

  // R4
  freq_cke_chk: assert property (@(posedge clk) disable iff (rst)
    freq_req_o |-> !cke_o);

  // R5
  srx_stable_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_o == 3'd3 |-> $past(clk_stable_i));

  // R11
  err_start_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(start_i));

  // R2
  mr1_dll_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd1 && mr_sel_o == 2'd1) |-> mr_data_o[0]);

  // R9
  done_cke_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> cke_o && !freq_req_o);

  // R10
  cmd_code_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_o <= 3'd4);

endmodule

bind dll_off_sequencer dll_off_sequencer_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .clk_stable_i (clk_stable_i),
  .cmd_o        (cmd_o),
  .mr_sel_o     (mr_sel_o),
  .mr_data_o    (mr_data_o),
  .cke_o        (cke_o),
  .freq_req_o   (freq_req_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/dll_off_sequencer_tb.sv
module dll_off_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0, mem_idle_i = 1'b1, clk_stable_i = 1'b0, odt_req_i = 1'b0;
  logic          rtt_nom_en_i = 1'b0, rtt_wr_en_i = 1'b0, zq_en_i = 1'b0;
  logic [TW-1:0] t_mod_i = 1, t_cksre_i = 1, t_cksrx_i = 1, t_xs_i = 1, t_ckesr_i = 1;
  logic [AW-1:0] mr0_cfg_i = '0, mr1_cfg_i = '0, mr2_cfg_i = '0;
  logic [2:0]    cmd_o;
  logic [1:0]    mr_sel_o;
  logic [AW-1:0] mr_data_o;
  logic          cke_o, odt_o, freq_req_o, done_o, err_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int n_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dll_off_sequencer #(.TW(TW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mem_idle_i(mem_idle_i),
    .clk_stable_i(clk_stable_i), .odt_req_i(odt_req_i),
    .rtt_nom_en_i(rtt_nom_en_i), .rtt_wr_en_i(rtt_wr_en_i), .zq_en_i(zq_en_i),
    .t_mod_i(t_mod_i), .t_cksre_i(t_cksre_i), .t_cksrx_i(t_cksrx_i),
    .t_xs_i(t_xs_i), .t_ckesr_i(t_ckesr_i),
    .mr0_cfg_i(mr0_cfg_i), .mr1_cfg_i(mr1_cfg_i), .mr2_cfg_i(mr2_cfg_i),
    .cmd_o(cmd_o), .mr_sel_o(mr_sel_o), .mr_data_o(mr_data_o),
    .cke_o(cke_o), .odt_o(odt_o), .freq_req_o(freq_req_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d (run %0d)", tag, what, act, exp, n_run);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_err++;
        $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    end
  end

  // one full transition; the call starts at a falling edge
  task automatic run_seq(input int tm, input int tse, input int tsx, input int txs,
                         input int tce, input bit zq, input bit nom, input bit wr,
                         input int dly, input bit glitch, input int busy_at, input string pre);
    int s, f, j, x, m0, m1, z, d;
    bit term;
    logic [AW-1:0] v0, v1, v2;
    int e_cmd;
    n_run++;
    s  = eff(tm);
    f  = s + eff(tse);
    j  = f + dly;
    x  = imax(j + eff(tsx), s + eff(tce));
    m0 = x + eff(txs);
    m1 = m0 + eff(tm);
    z  = m1 + eff(tm);
    d  = zq ? z + 1 : m1 + eff(tm);
    term = nom | wr;
    v0 = AW'(n_run * 37 + 5);
    v1 = AW'((n_run * 52) & 16'hfffe);
    v2 = AW'(n_run * 11 + 2);
    t_mod_i = TW'(tm); t_cksre_i = TW'(tse); t_cksrx_i = TW'(tsx);
    t_xs_i = TW'(txs); t_ckesr_i = TW'(tce);
    zq_en_i = zq; rtt_nom_en_i = nom; rtt_wr_en_i = wr;
    mr0_cfg_i = v0; mr1_cfg_i = v1; mr2_cfg_i = v2;
    clk_stable_i = 1'b0; odt_req_i = 1'b1; mem_idle_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t <= d; t++) begin
      e_cmd = 0;
      if (t == 0 || t == m0 || t == m1) e_cmd = 1;
      else if (t == s) e_cmd = 2;
      else if (t == x) e_cmd = 3;
      else if (zq && t == z) e_cmd = 4;
      if (t == 0) begin
        chk({pre, "R2"}, "MR1 command", int'(cmd_o), 1);
        chk({pre, "R2"}, "MR1 select", int'(mr_sel_o), 1);
        chk({pre, "R2"}, "MR1 data", int'(mr_data_o), int'(v1 | AW'(1)));
      end else if (t == s) begin
        chk({pre, "R3"}, "SRE timing", int'(cmd_o), 2);
      end else if (t == x) begin
        chk({pre, "R5"}, "SRX timing", int'(cmd_o), 3);
      end else if (t == m0) begin
        chk({pre, "R8"}, "MR2 command", int'(cmd_o), 1);
        chk({pre, "R8"}, "MR2 select", int'(mr_sel_o), 2);
        chk({pre, "R8"}, "MR2 data", int'(mr_data_o), int'(v2));
      end else if (t == m1) begin
        chk({pre, "R8"}, "MR0 command", int'(cmd_o), 1);
        chk({pre, "R8"}, "MR0 select", int'(mr_sel_o), 0);
        chk({pre, "R8"}, "MR0 data", int'(mr_data_o), int'(v0));
      end else if (zq && t == z) begin
        chk({pre, "R9"}, "ZQCL timing", int'(cmd_o), 4);
      end else begin
        chk({pre, "R10"}, "idle command", int'(cmd_o), e_cmd);
      end
      chk({pre, (t < x) ? "R3" : "R6"}, "cke", int'(cke_o), (t >= s && t < x) ? 0 : 1);
      chk({pre, "R4"}, "freq_req", int'(freq_req_o), (t >= f && t < x) ? 1 : 0);
      chk({pre, "R7"}, "odt", int'(odt_o), (term && t < d) ? 0 : 1);
      chk({pre, "R9"}, "done", int'(done_o), (t == d) ? 1 : 0);
      chk({pre, "R11"}, "err", int'(err_o), (busy_at >= 0 && t == busy_at + 1) ? 1 : 0);
      if (glitch && t == f) clk_stable_i = 1'b1;
      if (glitch && t == f + 1) clk_stable_i = 1'b0;
      if (t == j) clk_stable_i = 1'b1;
      start_i = (t == busy_at);
      @(negedge clk);
    end
    chk({pre, "R9"}, "done held", int'(done_o), 1);
    chk({pre, "R10"}, "command after done", int'(cmd_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk("R1", "cmd in reset", int'(cmd_o), 0);
    chk("R1", "cke in reset", int'(cke_o), 1);
    chk("R1", "odt in reset", int'(odt_o), 0);
    chk("R1", "freq in reset", int'(freq_req_o), 0);
    chk("R1", "done in reset", int'(done_o), 0);
    chk("R1", "err in reset", int'(err_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "cmd after reset", int'(cmd_o), 0);
    chk("R1", "cke after reset", int'(cke_o), 1);
    chk("R1", "done after reset", int'(done_o), 0);

    // R11: start while the device is not idle is refused
    mem_idle_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; mem_idle_i = 1'b1;
    chk("R11", "err on non-idle start", int'(err_o), 1);
    chk("R11", "no command on refused start", int'(cmd_o), 0);
    @(negedge clk);
    chk("R11", "err one cycle", int'(err_o), 0);
    chk("R11", "still no command", int'(cmd_o), 0);
    chk("R11", "cke unchanged", int'(cke_o), 1);

    // main sweep
    for (int tm = 1; tm <= 2; tm++)
      for (int tse = 1; tse <= 2; tse++)
        for (int tsx = 1; tsx <= 3; tsx++)
          for (int txs = 1; txs <= 2; txs++)
            for (int tce = 1; tce <= 6; tce++)
              for (int zq = 0; zq <= 1; zq++)
                for (int tr = 0; tr <= 3; tr++)
                  for (int dl = 0; dl <= 2; dl += 2) begin
                    run_seq(tm, tse, tsx, txs, tce, zq[0], tr[0], tr[1], dl, 1'b0, -1, "");
                    repeat (2) @(negedge clk);
                  end

    // R5: a broken stable run restarts the count
    run_seq(1, 1, 2, 1, 1, 1'b0, 1'b1, 1'b0, 3, 1'b1, -1, "R5 ");
    run_seq(2, 1, 3, 2, 2, 1'b1, 1'b0, 1'b0, 4, 1'b1, -1, "R5 ");
    // R12: zero timing values behave as one
    run_seq(0, 0, 0, 0, 0, 1'b1, 1'b1, 1'b1, 0, 1'b0, -1, "R12 ");
    run_seq(0, 2, 0, 0, 3, 1'b0, 1'b0, 1'b1, 1, 1'b0, -1, "R12 ");
    // R11: start during a transition flags an error and is ignored
    run_seq(2, 2, 2, 2, 2, 1'b1, 1'b1, 1'b0, 1, 1'b0, 2, "R11 ");
    run_seq(1, 1, 1, 1, 6, 1'b0, 1'b0, 1'b0, 0, 1'b0, 5, "R11 ");

    // R11: refused start after done leaves done and the bus untouched
    mem_idle_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; mem_idle_i = 1'b1;
    chk("R11", "err after done", int'(err_o), 1);
    chk("R11", "done kept", int'(done_o), 1);
    chk("R11", "no command", int'(cmd_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule